// File: doc/BRIEF.md
# Console Transmit Register Interface

This block is the transmit half of a memory-mapped serial console. Software sees two registers. The status register at address 0 holds a ready flag and an interrupt-enable bit. The data register at address 1 can only be written. Writing a character to the data register clears the ready flag. The block then offers the character to a downstream serial transmitter over a valid/ready handshake. The ready flag stays clear until that transmitter accepts the character.

If the transmitter is busy, the character stays on the handshake and the block keeps offering it. Completion is only reported after acceptance. When the character goes out, the ready flag is set again. If interrupt-enable is set, a level interrupt request is raised, and it stays up until software writes new data or clears the enable.

A mode input chooses how each character is treated:
- full 8-bit, where the character goes out unchanged;
- 7-bit, where the top bit is cleared;
- 7-bit printable-only, where most control codes are discarded.

A discarded character is treated as complete at once, without going onto the handshake.

Top module: `txcons_top`

## Requirements
- R1: After reset, the status register reads 0x0080 (ready set, interrupt-enable clear), `txIrq` is 0 and `txValid` is 0.
- R2: In the status register, the ready flag is bit 7 and interrupt-enable is bit 6. All other bits read 0. A status write changes only interrupt-enable. Reading address 1 returns 0.
- R3: A write to address 1 keeps only bits 7:0. From the next cycle on, the ready flag is clear, `txIrq` is 0 and `txValid` is 1 with the character on `txData`.
- R4: In a cycle where `txValid` and `txReady` are both 1, the character is accepted. From the next cycle, `txValid` is 0 and the ready flag is 1. `txIrq` then equals the interrupt-enable value that holds after that edge.
- R5: While `txReady` is 0, `txValid` stays 1, `txData` holds its value and the ready flag stays 0.
- R6: Writing the status register with bit 6 clear drops `txIrq` from the next cycle.
- R7: Writing bit 6 as 1 raises `txIrq` if the ready flag is set and interrupt-enable was 0. If the ready flag is clear, it does not.
- R8: `modeSel` 0 (and 3) sends all 8 bits. `modeSel` 1 sends the character with bit 7 cleared.
- R9: `modeSel` 2 sends the character with bit 7 cleared, except for discarded characters. A character is discarded when its low 7 bits are below 0x20 or equal to 0x7F, unless they are 0x07, 0x08, 0x09, 0x0A or 0x0D. A discarded character never raises `txValid`. It sets the ready flag on the next cycle and sets `txIrq` to interrupt-enable.
- R10: A data write while a character is still waiting replaces it. Only the newer character is offered, and only one transfer follows.
- R11: `txIrq` is a level. It is only ever 1 while both the ready flag and interrupt-enable are 1, and it stays 1 without further activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 data |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for the register selected by regAddr |
| modeSel | input | 2 | Character mode: 0 8-bit, 1 7-bit, 2 printable 7-bit, 3 as 0 |
| txValid | output | 1 | Character offered to the transmitter |
| txData | output | 8 | Character being offered |
| txReady | input | 1 | Transmitter accepts the character |
| txIrq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an acceptance by the transmitter in the same cycle as a status write that turns interrupt-enable on. The interrupt must come from the new enable value, not the old one. The bench gets there by:
1. leaving a character stalled;
2. then, on one falling edge, raising `txReady` and starting the status write together.

Stall holding is exercised by keeping `txReady` low for several cycles. Replacement is exercised by two back-to-back data writes before any acceptance.

// File: rtl/txcons_pkg.sv
package txcons_pkg;

  typedef enum logic [1:0] {
    MODE_FULL8  = 2'd0,
    MODE_SEVEN  = 2'd1,
    MODE_PRINT7 = 2'd2,
    MODE_SPARE  = 2'd3
  } txModeE;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadByte;
  } dpStrobeS;

  // Control codes allowed through in printable mode
  function automatic logic isAllowedCtl(input logic [6:0] c);
    return (c == 7'h07) || (c == 7'h08) || (c == 7'h09) ||
           (c == 7'h0A) || (c == 7'h0D);
  endfunction

  function automatic logic isCtl(input logic [6:0] c);
    return (c < 7'h20) || (c == 7'h7F);
  endfunction

endpackage

// File: rtl/txcons_datapath.sv
module txcons_datapath
  import txcons_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobeS          strobe,
  input  logic [CHAR_W-1:0] wrChar,
  input  logic [1:0]        modeSel,
  output logic [CHAR_W-1:0] charOut,
  output logic              dropNow
);

  localparam int LOW_W = CHAR_W - 1;

  txModeE            modeNow;
  logic [CHAR_W-1:0] converted;
  logic [LOW_W-1:0]  lowBits;
  logic [CHAR_W-1:0] charReg;

  assign modeNow = txModeE'(modeSel);
  assign lowBits = wrChar[LOW_W-1:0];

  always_comb begin
    converted = wrChar;
    dropNow   = 1'b0;
    unique case (modeNow)
      MODE_SEVEN: converted = {1'b0, lowBits};
      MODE_PRINT7: begin
        converted = {1'b0, lowBits};
        dropNow   = isCtl(lowBits) && !isAllowedCtl(lowBits);
      end
      default: converted = wrChar;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) charReg <= '0;
    else if (strobe.loadByte) charReg <= converted;
  end

  assign charOut = charReg;

endmodule

// File: rtl/txcons_control.sv
module txcons_control
  import txcons_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dataWr,
  input  logic     statusWr,
  input  logic     ieWrBit,
  input  logic     dropNow,
  input  logic     txReady,
  output dpStrobeS strobe,
  output logic     pending,
  output logic     doneFlag,
  output logic     ieFlag,
  output logic     irqOut
);

  logic ieNext;

  assign ieNext          = statusWr ? ieWrBit : ieFlag;
  assign strobe.loadByte = dataWr && !dropNow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      doneFlag <= 1'b1;
      ieFlag   <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      ieFlag <= ieNext;
      if (dataWr && !dropNow) begin
        pending  <= 1'b1;
        doneFlag <= 1'b0;
        irqOut   <= 1'b0;
      end else if (dataWr) begin
        pending  <= 1'b0;
        doneFlag <= 1'b1;
        irqOut   <= ieNext;
      end else if (pending && txReady) begin
        pending  <= 1'b0;
        doneFlag <= 1'b1;
        irqOut   <= ieNext;
      end else if (statusWr) begin
        if (!ieWrBit) irqOut <= 1'b0;
        else if (doneFlag && !ieFlag) irqOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/txcons_top.sv
module txcons_top #(
  parameter int BUS_W    = 16,
  parameter int CHAR_W   = 8,
  parameter int DONE_BIT = 7,
  parameter int IE_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic [1:0]        modeSel,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txReady,
  output logic              txIrq
);
  import txcons_pkg::*;

  dpStrobeS strobe;
  logic     dropNow;
  logic     doneFlag;
  logic     ieFlag;
  logic     dataWr;
  logic     statusWr;
  logic     unusedHigh;

  assign dataWr     = regWrEn && regAddr;
  assign statusWr   = regWrEn && !regAddr;
  assign unusedHigh = ^regWrData[BUS_W-1:CHAR_W];

  txcons_datapath #(.CHAR_W(CHAR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrChar(regWrData[CHAR_W-1:0]), .modeSel(modeSel),
    .charOut(txData), .dropNow(dropNow)
  );

  txcons_control u_ctl (
    .clk(clk), .rst_n(rst_n), .dataWr(dataWr), .statusWr(statusWr),
    .ieWrBit(regWrData[IE_BIT]), .dropNow(dropNow), .txReady(txReady),
    .strobe(strobe), .pending(txValid), .doneFlag(doneFlag),
    .ieFlag(ieFlag), .irqOut(txIrq)
  );

  always_comb begin
    regRdData = '0;
    if (!regAddr) begin
      regRdData[DONE_BIT] = doneFlag;
      regRdData[IE_BIT]   = ieFlag;
    end
  end

endmodule

// File: rtl/txcons_checker.sv
module txcons_checker #(
  parameter int BUS_W  = 16,
  parameter int CHAR_W = 8,
  parameter int IE_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [BUS_W-1:0]  regWrData,
  input logic [1:0]        modeSel,
  input logic              txValid,
  input logic [CHAR_W-1:0] txData,
  input logic              txReady,
  input logic              txIrq,
  input logic              doneFlag,
  input logic              ieFlag
);

  AST_IRQ_NEEDS_DONE_IE: assert property (@(posedge clk) disable iff (!rst_n)
    txIrq |-> (doneFlag && ieFlag)); // R11

  AST_VALID_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |-> !doneFlag); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady && !(regWrEn && regAddr)) |=> (txValid && $stable(txData))); // R5

  AST_ACCEPT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady && !(regWrEn && regAddr)) |=> (doneFlag && !txValid)); // R4

  AST_IE_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && !regAddr && !regWrData[IE_BIT]) |=> !txIrq); // R6

  AST_DATA_WR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr && modeSel != 2'd2) |=> (txValid && !doneFlag && !txIrq)); // R3

endmodule

bind txcons_top txcons_checker #(.BUS_W(BUS_W), .CHAR_W(CHAR_W), .IE_BIT(IE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .modeSel(modeSel), .txValid(txValid),
  .txData(txData), .txReady(txReady), .txIrq(txIrq),
  .doneFlag(doneFlag), .ieFlag(ieFlag)
);

// File: tb/sim_txcons_top.sv
`timescale 1ns/1ps
module sim_txcons_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [1:0]  modeSel = 2'd0;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        txIrq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  txcons_top u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .modeSel(modeSel),
    .txValid(txValid), .txData(txData), .txReady(txReady), .txIrq(txIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic rdStatus(output logic [15:0] v);
    regAddr = 1'b0; #0.5; v = regRdData;
  endtask

  task automatic accept();
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk); rst_n = 1'b1;
    rdStatus(v);
    chk("R1 status", v, 32'h80);
    chk("R1 irq", txIrq, 0);
    chk("R1 valid", txValid, 0);
  endtask

  task automatic t_layout();
    logic [15:0] v;
    wr(0, 16'hFFFF);
    rdStatus(v);
    chk("R2 layout all ones", v, 32'hC0);
    chk("R7 enable raises irq", txIrq, 1);
    wr(0, 16'hFFBF);
    rdStatus(v);
    chk("R2 done untouched", v, 32'h80);
    chk("R6 disable clears irq", txIrq, 0);
    regAddr = 1'b1; #0.5;
    chk("R2 data reads zero", regRdData, 0);
    regAddr = 1'b0;
  endtask

  task automatic t_send8();
    logic [15:0] v;
    modeSel = 2'd0;
    wr(1, 16'h01C5);
    chk("R3 valid", txValid, 1);
    chk("R3 low byte", txData, 32'hC5);
    rdStatus(v);
    chk("R3 done clear", v, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 stall valid", txValid, 1);
      chk("R5 stall data", txData, 32'hC5);
      rdStatus(v);
      chk("R5 stall not done", v, 0);
    end
    accept();
    chk("R4 valid drops", txValid, 0);
    rdStatus(v);
    chk("R4 done set", v, 32'h80);
    chk("R4 irq off with ie 0", txIrq, 0);
  endtask

  task automatic t_irqAccept();
    logic [15:0] v;
    wr(0, 16'h0040);
    chk("R7 irq on enable", txIrq, 1);
    wr(1, 16'h0033);
    chk("R3 write clears irq", txIrq, 0);
    wr(0, 16'h0040);
    chk("R7 no irq while busy", txIrq, 0);
    accept();
    chk("R4 irq on accept", txIrq, 1);
    rdStatus(v);
    chk("R4 status", v, 32'hC0);
    repeat (3) @(negedge clk);
    chk("R11 level held", txIrq, 1);
    wr(0, 16'h0040);
    chk("R11 rewrite keeps irq", txIrq, 1);
    wr(0, 16'h0000);
    chk("R6 clear irq", txIrq, 0);
  endtask

  task automatic t_coincide();
    logic [15:0] v;
    wr(1, 16'h0044);
    @(negedge clk);
    txReady = 1'b1; regWrEn = 1'b1; regAddr = 1'b0; regWrData = 16'h0040;
    @(negedge clk);
    txReady = 1'b0; regWrEn = 1'b0;
    rdStatus(v);
    chk("R4 coincide status", v, 32'hC0);
    chk("R7 coincide irq", txIrq, 1);
    wr(0, 16'h0000);
  endtask

  task automatic t_mode7();
    modeSel = 2'd1;
    wr(1, 16'h00C1);
    chk("R8 seven-bit", txData, 32'h41);
    accept();
    modeSel = 2'd0;
    wr(1, 16'h00C1);
    chk("R8 eight-bit", txData, 32'hC1);
    accept();
  endtask

  task automatic t_print();
    logic [15:0] v;
    modeSel = 2'd2;
    wr(0, 16'h0040);
    wr(1, 16'h008D);
    chk("R9 CR passes", txValid, 1);
    chk("R9 CR data", txData, 32'h0D);
    chk("R9 irq cleared", txIrq, 0);
    accept();
    wr(1, 16'h0001);
    chk("R9 ctl dropped", txValid, 0);
    rdStatus(v);
    chk("R9 drop done", v, 32'hC0);
    chk("R9 drop irq", txIrq, 1);
    wr(1, 16'h007F);
    chk("R9 DEL dropped", txValid, 0);
    chk("R9 DEL irq", txIrq, 1);
    wr(1, 16'h00E1);
    chk("R9 printable", txData, 32'h61);
    chk("R9 printable valid", txValid, 1);
    accept();
    wr(1, 16'h0009);
    chk("R9 HT passes", txData, 32'h09);
    chk("R9 HT valid", txValid, 1);
    accept();
    wr(0, 16'h0000);
    modeSel = 2'd0;
  endtask

  task automatic t_replace();
    wr(1, 16'h0011);
    wr(1, 16'h0022);
    chk("R10 replaced data", txData, 32'h22);
    chk("R10 valid", txValid, 1);
    accept();
    chk("R10 one transfer", txValid, 0);
    @(negedge clk);
    chk("R10 stays idle", txValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_layout();
    t_send8();
    t_irqAccept();
    t_coincide();
    t_mode7();
    t_print();
    t_replace();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule